// File: doc/BRIEF.md
# Machine-Cycle and Peripheral Tick Rate Selector

This block divides an oscillator clock into six single-cycle tick streams. One stream paces the CPU machine cycle. The other five pace the serial port, timer 0, timer 1, timer 2 and the counter array. Each stream repeats every 6 or every 12 oscillator periods. A byte-wide control register selects the rate of each stream. Its bit 0 is a global double-speed enable, and bits 1 to 5 let individual peripherals fall back to the standard rate.

The global bit works with the opposite sense to the per-peripheral bits. When the global bit is set, the CPU runs fast. When a per-peripheral bit is set, that peripheral runs slow. When the global bit is clear, the per-peripheral bits are ignored and everything runs at 12 periods.

At reset, the global bit takes its value from a hardware configuration input. The register is always written and read as a whole byte. A new rate takes effect only when the affected divider next wraps, so no tick interval is ever shortened.

Top module: `clk_rate_sel`

## Requirements
- R1: A write with `wr_en` high stores `wr_data[5:0]`, and `rd_data[5:0]` shows it from the next cycle. `rd_data[7:6]` always reads 0, whatever was written.
- R2: While `rst_n` is low, no tick is produced. After reset, `rd_data` equals `{7'b0, cfg_fast}`.
- R3: When bit 0 is 0, every tick, CPU and peripheral, repeats every 12 cycles, whatever bits 1 to 5 hold.
- R4: When bit 0 is 1, `cpu_tick` repeats every 6 cycles.
- R5: When bit 0 is 1, `per_tick[i]` repeats every 6 cycles if bit i+1 is 0, and every 12 cycles if bit i+1 is 1. The mapping is: bit 1 is the serial port (`per_tick[0]`), bit 2 is timer 0, bit 3 is timer 1, bit 4 is timer 2, and bit 5 is the counter array (`per_tick[4]`).
- R6: Every tick is high for exactly one cycle.
- R7: After the first tick following reset, the gap between successive ticks of any output is only ever 6 or 12 cycles, even when the register is rewritten at any point within a period. A new rate is adopted at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fast | input | 1 | Hardware configuration default for the global speed bit |
| wr_en | input | 1 | Register write strobe (whole byte) |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents |
| cpu_tick | output | 1 | CPU machine-cycle tick |
| per_tick | output | 5 | Peripheral ticks: serial, timer 0, timer 1, timer 2, counter array |

## Verification
The hardest case to reach is a rate change that arrives in the middle of a divider's period, since the write has to land at many different phases relative to each divider. The stimulus switches between all-fast, all-slow and mixed settings. It waits a different number of cycles between writes, sweeping every offset inside a 12-cycle period. Meanwhile a monitor measures every tick gap on all six outputs.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;
  localparam int unsigned FAST_DIV  = 6;
  localparam int unsigned SLOW_DIV  = 12;
  localparam int unsigned NUM_PERIPH = 5;
  localparam int unsigned CTRL_W    = NUM_PERIPH + 1;
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned GLOBAL_BIT = 0;
endpackage

// File: rtl/rate_ctrl_reg.sv
module rate_ctrl_reg #(
  parameter int unsigned CTRL_W = clk_rate_pkg::CTRL_W,
  parameter int unsigned BUS_W  = clk_rate_pkg::BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fast,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [CTRL_W-1:0] ctrl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= {{(CTRL_W-1){1'b0}}, cfg_fast};
    end else if (wr_en) begin
      ctrl <= wr_data[CTRL_W-1:0];
    end
  end
endmodule

// File: rtl/tick_div.sv
module tick_div #(
  parameter int unsigned FAST_DIV = clk_rate_pkg::FAST_DIV,
  parameter int unsigned SLOW_DIV = clk_rate_pkg::SLOW_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_fast,
  input  logic fast_req,
  output logic tick
);
  localparam int unsigned CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt;
  logic          fast_q;
  logic [CW-1:0] lim;

  assign lim  = fast_q ? FAST_LIM : SLOW_LIM;
  assign tick = (cnt == lim);

  // The rate is latched only at the wrap, so a period is never cut short.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      fast_q <= rst_fast;
    end else if (tick) begin
      cnt    <= '0;
      fast_q <= fast_req;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_rate_sel.sv
module clk_rate_sel
  import clk_rate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_fast,
  input  logic                  wr_en,
  input  logic [BUS_W-1:0]      wr_data,
  output logic [BUS_W-1:0]      rd_data,
  output logic                  cpu_tick,
  output logic [NUM_PERIPH-1:0] per_tick
);
  logic [CTRL_W-1:0] ctrl;
  logic              glob;

  rate_ctrl_reg #(.CTRL_W(CTRL_W), .BUS_W(BUS_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl)
  );

  assign glob    = ctrl[GLOBAL_BIT];
  assign rd_data = {{(BUS_W-CTRL_W){1'b0}}, ctrl};

  tick_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_cpu_div (
    .clk(clk), .rst_n(rst_n), .rst_fast(cfg_fast),
    .fast_req(glob), .tick(cpu_tick)
  );

  // Peripheral selects: set bit means slow, and counts only under the global bit.
  // After reset every peripheral select is clear, so each divider starts at cfg_fast.
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
    tick_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .rst_fast(cfg_fast),
      .fast_req(glob & ~ctrl[i+1]), .tick(per_tick[i])
    );
  end
endmodule

// File: rtl/clk_rate_sel_chk.sv
module clk_rate_sel_chk
  import clk_rate_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_fast,
  input logic                  wr_en,
  input logic [BUS_W-1:0]      wr_data,
  input logic [BUS_W-1:0]      rd_data,
  input logic                  cpu_tick,
  input logic [NUM_PERIPH-1:0] per_tick
);
  localparam int unsigned NT = NUM_PERIPH + 1;
  logic [NT-1:0] ticks;
  assign ticks = {per_tick, cpu_tick};

  // R1
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:CTRL_W] == '0);
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[CTRL_W-1:0] == $past(wr_data[CTRL_W-1:0]));
  // R2
  a_r2_reset_value: assert property (@(posedge clk)
    !rst_n |=> rd_data == {{(BUS_W-1){1'b0}}, $past(cfg_fast)});
  a_r2_quiet_reset: assert property (@(posedge clk)
    !rst_n |=> ticks == '0);

  for (genvar i = 0; i < NT; i++) begin : g_gap
    logic [7:0] gap;
    logic       seen;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gap  <= '0;
        seen <= 1'b0;
      end else if (ticks[i]) begin
        gap  <= 8'd1;
        seen <= 1'b1;
      end else if (gap != 8'hFF) begin
        gap <= gap + 8'd1;
      end
    end
    // R6
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ticks[i] |=> !ticks[i]);
    // R7
    a_r7_gap_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (ticks[i] && seen) |-> (gap == 8'(FAST_DIV) || gap == 8'(SLOW_DIV)));
  end
endmodule

bind clk_rate_sel clk_rate_sel_chk u_chk (.*);

// File: tb/tb_clk_rate_sel.sv
module tb_clk_rate_sel;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_fast = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cpu_tick;
  logic [4:0] per_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  clk_rate_sel dut (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cpu_tick(cpu_tick), .per_tick(per_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5:0] ticks;
  assign ticks = {per_tick, cpu_tick};

  int gap[6], last_gap[6], seen[6], bad[6], wide[6];
  logic [5:0] prev_t;

  always @(negedge clk) begin
    for (int i = 0; i < 6; i++) begin
      if (!rst_n) begin
        gap[i] = 0; last_gap[i] = 0; seen[i] = 0;
      end else begin
        gap[i] = gap[i] + 1;
        if (ticks[i] && prev_t[i]) wide[i] = wide[i] + 1;
        if (ticks[i]) begin
          if (seen[i] != 0 && gap[i] != 6 && gap[i] != 12) bad[i] = bad[i] + 1;
          last_gap[i] = gap[i];
          gap[i] = 0;
          seen[i] = 1;
        end
      end
    end
    prev_t = rst_n ? ticks : 6'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_gap(input logic [7:0] v, input int idx);
    if (idx == 0) return v[0] ? 6 : 12;
    return (v[0] && !v[idx]) ? 6 : 12;
  endfunction

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: reset state and quiet ticks under reset
  task automatic t_reset(input logic cf);
    bit quiet = 1;
    cfg_fast = cf;
    @(negedge clk); rst_n = 1'b0;
    repeat (15) begin
      @(negedge clk);
      if (ticks != 6'b0) quiet = 0;
    end
    check(quiet, "R2 no tick in reset", 0, 0);
    check(rd_data == {7'b0, cf}, "R2 reset value", rd_data, {7'b0, cf});
    rst_n = 1'b1;
    wait_cyc(40);
    for (int i = 0; i < 6; i++)
      check(last_gap[i] == (cf ? 6 : 12), "R2 post-reset rate", last_gap[i], cf ? 6 : 12);
  endtask

  // R1: readback and masking of upper bits
  task automatic t_readback(input logic [7:0] v);
    write_reg(v);
    check(rd_data == {2'b00, v[5:0]}, "R1 readback", rd_data, {2'b00, v[5:0]});
  endtask

  // R3/R4/R5: steady spacing for a configuration
  task automatic t_spacing(input logic [7:0] v);
    write_reg(v);
    wait_cyc(40);
    for (int i = 0; i < 6; i++) begin
      int e = exp_gap(v, i);
      if (!v[0])       check(last_gap[i] == e, "R3 slow when global clear", last_gap[i], e);
      else if (i == 0) check(last_gap[i] == e, "R4 cpu fast", last_gap[i], e);
      else             check(last_gap[i] == e, "R5 peripheral select", last_gap[i], e);
    end
  endtask

  // R7: rewrites at every phase of a period
  task automatic t_midperiod();
    for (int i = 0; i < 6; i++) bad[i] = 0;
    for (int off = 0; off < 13; off++) begin
      write_reg(8'h01);
      wait_cyc(off);
      write_reg(8'h3F);
      wait_cyc((off * 7) % 13);
      write_reg(8'h15);
      wait_cyc((off * 5) % 11);
      write_reg(8'h00);
      wait_cyc(off % 4);
    end
    wait_cyc(30);
    for (int i = 0; i < 6; i++)
      check(bad[i] == 0, "R7 legal gaps after rewrites", bad[i], 0);
  endtask

  // R6: pulse width one cycle
  task automatic t_width();
    for (int i = 0; i < 6; i++)
      check(wide[i] == 0, "R6 single-cycle ticks", wide[i], 0);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin bad[i] = 0; wide[i] = 0; end
    wait_cyc(3);
    t_reset(1'b1);
    t_reset(1'b0);
    t_readback(8'hFF);
    t_readback(8'h2A);
    t_readback(8'h00);
    t_spacing(8'h00);
    t_spacing(8'h3E);
    t_spacing(8'h01);
    t_spacing(8'h3F);
    for (int b = 1; b < 6; b++) t_spacing(8'h01 | (8'h01 << b));
    t_spacing(8'h15);
    t_spacing(8'hC1);
    t_midperiod();
    t_width();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule